// File: doc/BRIEF.md
# Crystal Activity Watchdog with PLL Base-Clock Fallback

This block watches a crystal oscillator input while the PLL is bypassed and the CPU would otherwise run straight from the crystal. A free-running reference clock measures time. The crystal signal is brought into that domain through a synchronizer, and each of its transitions restarts a quiet-time window. If the window runs out before another transition arrives, the block decides the crystal has stopped. It then moves the CPU clock select over to the PLL's free-running base output, which lies between 750 kHz and 3 MHz. That decision is latched until reset.

A configuration bit turns the function off. While that bit is set and the PLL is bypassed, no monitoring takes place, the crystal stays the only clock source, and the block asks for the PLL to be powered down. The block drives only the select and the power-down request. The clock multiplexer and the analog PLL sit outside it. The window length is a parameter counted in reference-clock cycles, chosen so that it covers at least 1 µs.

Top module: `osc_activity_watchdog`

## Requirements
- R1: After reset, `osc_fail` is 0 and `clk_sel_pll` is 0, so the crystal path is selected.
- R2: Monitoring is active only when `mon_disable` is 0, `pll_bypass` is 1 and no fault has been latched.
- R3: The crystal input passes through `SYNC_STAGES` flops (two by default) before edge detection. With monitoring active and no transition, `osc_fail` rises on the `TIMEOUT_CYCLES`-th consecutive quiet rising edge of `clk`. For a crystal transition applied between clock edges, that is `TIMEOUT_CYCLES`+3 edges after the transition.
- R4: A rising or a falling crystal transition restarts the full window. A crystal that toggles more often than once per window never raises `osc_fail`.
- R5: Once `osc_fail` is 1, it stays 1 until `rst_n` is asserted, even if crystal transitions return or monitoring is disabled.
- R6: `pll_pwrdn` is 1 exactly when `mon_disable` is 1, `pll_bypass` is 1 and `osc_fail` is 0.
- R7: `clk_sel_pll` is 1 exactly when a fault is latched (it equals `osc_fail`).
- R8: While `mon_disable` is 1 or `pll_bypass` is 0, no quiet time, however long, raises `osc_fail`.
- R9: When monitoring becomes active, the window starts afresh. With no transition, `osc_fail` rises on the `TIMEOUT_CYCLES`-th edge after activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock used for timing |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_in | input | 1 | Crystal oscillator signal, asynchronous to `clk` |
| pll_bypass | input | 1 | 1 when the PLL is bypassed and the crystal drives the CPU |
| mon_disable | input | 1 | Configuration bit; 1 turns monitoring off |
| clk_sel_pll | output | 1 | CPU clock select; 1 chooses the PLL base output |
| pll_pwrdn | output | 1 | Request to power the PLL down |
| osc_fail | output | 1 | Latched crystal failure flag |

## Verification
Some properties are checked by the assertions on every cycle:
- the fault flag is sticky;
- it rises only one cycle after the window expires;
- it never rises while monitoring is off;
- the power-down request never coincides with the PLL being selected;
- every detected transition reloads the window.

Other behaviour can only be shown by the bench's scenarios. These include the exact edge on which the fault appears after a transition (both rising and falling), the fresh window after enabling, and the clearing by reset. The bench checks each of these against cycle counts derived from the timeout parameter.

// File: rtl/owd_pkg.sv
package owd_pkg;

  // Whether the crystal path or the PLL base clock drives the CPU
  typedef enum logic {
    OWD_CRYSTAL  = 1'b0,
    OWD_FALLBACK = 1'b1
  } owd_state_e;

  // Width of a down-counter that must hold values 0 .. limit-1
  function automatic int unsigned window_width(int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  // Next value of the quiet-time counter
  function automatic logic [31:0] window_next(logic [31:0] cur,
                                              logic        restart,
                                              logic [31:0] reload);
    if (restart)        return reload;
    else if (cur == 0)  return 32'd0;
    else                return cur - 32'd1;
  endfunction

  // Power-down request rule
  function automatic logic pwrdn_rule(logic disable_bit, logic bypass,
                                      logic failed);
    return disable_bit & bypass & ~failed;
  endfunction

endpackage

// File: rtl/owd_sync.sv
module owd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/owd_edge.sv
module owd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= s;
  end

  assign edge_o = s ^ prev_q;
endmodule

// File: rtl/owd_timer.sv
module owd_timer #(
  parameter int unsigned LIMIT = 100,
  localparam int unsigned CW = owd_pkg::window_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic          expired,
  output logic [CW-1:0] count
);
  localparam logic [31:0] RELOAD = 32'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(RELOAD);
    else        cnt_q <= CW'(owd_pkg::window_next(32'(cnt_q), restart, RELOAD));
  end

  assign expired = !restart && (cnt_q == '0);
  assign count   = cnt_q;
endmodule

// File: rtl/owd_fallback.sv
module owd_fallback (
  input  logic clk,
  input  logic rst_n,
  input  logic watch_req,
  input  logic expired,
  input  logic mon_disable,
  input  logic pll_bypass,
  output logic active,
  output logic failed,
  output logic pwrdn
);
  import owd_pkg::*;

  owd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (state_q == OWD_CRYSTAL && watch_req && expired) state_d = OWD_FALLBACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= OWD_CRYSTAL;
    else        state_q <= state_d;
  end

  assign failed = (state_q == OWD_FALLBACK);
  assign active = watch_req && !failed;
  assign pwrdn  = pwrdn_rule(mon_disable, pll_bypass, failed);
endmodule

// File: rtl/osc_activity_watchdog.sv
module osc_activity_watchdog #(
  parameter int unsigned TIMEOUT_CYCLES = 100,
  parameter int unsigned SYNC_STAGES    = 2,
  localparam int unsigned CW = owd_pkg::window_width(TIMEOUT_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xtal_in,
  input  logic pll_bypass,
  input  logic mon_disable,
  output logic clk_sel_pll,
  output logic pll_pwrdn,
  output logic osc_fail
);
  // Named internal events, also observed by the checker
  logic          xtal_sync;
  logic          xtal_edge;
  logic          watch_req;
  logic          monitor_active;
  logic          window_restart;
  logic          window_expired;
  logic [CW-1:0] window_count;
  logic          fault_latched;

  assign watch_req      = !mon_disable && pll_bypass;
  assign window_restart = xtal_edge || !monitor_active;

  owd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(xtal_in), .q(xtal_sync)
  );

  owd_edge u_edge (
    .clk(clk), .rst_n(rst_n), .s(xtal_sync), .edge_o(xtal_edge)
  );

  owd_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(window_restart),
    .expired(window_expired), .count(window_count)
  );

  owd_fallback u_fallback (
    .clk(clk), .rst_n(rst_n), .watch_req(watch_req),
    .expired(window_expired), .mon_disable(mon_disable),
    .pll_bypass(pll_bypass), .active(monitor_active),
    .failed(fault_latched), .pwrdn(pll_pwrdn)
  );

  assign osc_fail    = fault_latched;
  assign clk_sel_pll = fault_latched;
endmodule

// File: rtl/osc_activity_watchdog_chk.sv
module osc_activity_watchdog_chk #(
  parameter int unsigned TIMEOUT_CYCLES = 100,
  localparam int unsigned CW = owd_pkg::window_width(TIMEOUT_CYCLES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pll_bypass,
  input logic          mon_disable,
  input logic          clk_sel_pll,
  input logic          pll_pwrdn,
  input logic          osc_fail,
  input logic          xtal_edge,
  input logic          window_expired,
  input logic [CW-1:0] window_count
);
  // R5: fault flag never clears without reset
  a_r5_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail |=> osc_fail);

  // R3: an expired window latches the fault on the next edge
  a_r3_expiry_sets_fail: assert property (@(posedge clk) disable iff (!rst_n)
    window_expired |=> osc_fail);

  // R3: the fault only appears after an expiry
  a_r3_fail_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_fail) |-> $past(window_expired));

  // R7: the select only moves after an expiry
  a_r7_select_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel_pll) |-> $past(window_expired));

  // R8: no fault while monitoring is off
  a_r8_idle_no_fail: assert property (@(posedge clk) disable iff (!rst_n)
    ((mon_disable || !pll_bypass) && !osc_fail) |=> !osc_fail);

  // R6: never power down the PLL while it is selected
  a_r6_pwrdn_not_selected: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pwrdn |-> !clk_sel_pll);

  // R4: a detected transition reloads the full window
  a_r4_edge_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    xtal_edge |=> (window_count == CW'(TIMEOUT_CYCLES - 1)));
endmodule

bind osc_activity_watchdog osc_activity_watchdog_chk #(
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_bypass(pll_bypass),
  .mon_disable(mon_disable), .clk_sel_pll(clk_sel_pll),
  .pll_pwrdn(pll_pwrdn), .osc_fail(osc_fail), .xtal_edge(xtal_edge),
  .window_expired(window_expired), .window_count(window_count)
);

// File: tb/osc_activity_watchdog_test.sv
module osc_activity_watchdog_test;
  localparam int unsigned LIMIT = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_in = 1'b0;
  logic pll_bypass = 1'b1;
  logic mon_disable = 1'b0;
  logic clk_sel_pll, pll_pwrdn, osc_fail;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  osc_activity_watchdog #(.TIMEOUT_CYCLES(LIMIT), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .xtal_in(xtal_in), .pll_bypass(pll_bypass),
    .mon_disable(mon_disable), .clk_sel_pll(clk_sel_pll),
    .pll_pwrdn(pll_pwrdn), .osc_fail(osc_fail)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic byp, logic dis);
    @(negedge clk);
    rst_n = 1'b0; xtal_in = 1'b0; pll_bypass = byp; mon_disable = dis;
    wait_cyc(3);
    rst_n = 1'b1;
  endtask

  // R1 and R9: reset state, then a fresh window from release
  task automatic t_reset_window();
    do_reset(1'b1, 1'b0);
    chk("R1", "osc_fail after reset", osc_fail, 1'b0);
    chk("R1", "clk_sel_pll after reset", clk_sel_pll, 1'b0);
    wait_cyc(LIMIT - 1);
    chk("R9", "fail one edge before window end", osc_fail, 1'b0);
    wait_cyc(1);
    chk("R9", "fail at window end", osc_fail, 1'b1);
    chk("R7", "select follows fault", clk_sel_pll, 1'b1);
  endtask

  // R4 and R3: toggling keeps the fault away; last transition sets timing
  task automatic t_timeout_after_edge(logic final_level);
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 40; i++) begin
      xtal_in = ~xtal_in;
      wait_cyc(10);
    end
    if (xtal_in != final_level) begin
      xtal_in = ~xtal_in;
      wait_cyc(10);
    end
    chk("R4", "no fault while toggling", osc_fail, 1'b0);
    wait_cyc(LIMIT + 2 - 10);
    chk("R3", "no fault before limit+3 edges", osc_fail, 1'b0);
    wait_cyc(1);
    chk("R3", final_level ? "fault after rising edge" : "fault after falling edge",
        osc_fail, 1'b1);
  endtask

  // R8, R6, R2, R9: disabled, then enabled
  task automatic t_disabled_then_enabled();
    do_reset(1'b1, 1'b1);
    wait_cyc(3 * LIMIT);
    chk("R8", "no fault while disabled", osc_fail, 1'b0);
    chk("R6", "pwrdn while disabled and bypassed", pll_pwrdn, 1'b1);
    chk("R2", "crystal selected while disabled", clk_sel_pll, 1'b0);
    mon_disable = 1'b0;
    #1;
    chk("R6", "no pwrdn when enabled", pll_pwrdn, 1'b0);
    wait_cyc(LIMIT - 1);
    chk("R9", "fresh window after enable", osc_fail, 1'b0);
    wait_cyc(1);
    chk("R9", "fault at end of fresh window", osc_fail, 1'b1);
    mon_disable = 1'b1;
    wait_cyc(2);
    chk("R6", "no pwrdn once fallen back", pll_pwrdn, 1'b0);
    chk("R5", "fault holds after disable", osc_fail, 1'b1);
  endtask

  // R8 and R6: PLL not bypassed
  task automatic t_not_bypassed();
    do_reset(1'b0, 1'b0);
    wait_cyc(3 * LIMIT);
    chk("R8", "no fault when not bypassed", osc_fail, 1'b0);
    chk("R6", "no pwrdn when not bypassed", pll_pwrdn, 1'b0);
    mon_disable = 1'b1;
    wait_cyc(1);
    chk("R6", "no pwrdn disabled but not bypassed", pll_pwrdn, 1'b0);
  endtask

  // R5, R7, R1: sticky fault, cleared only by reset
  task automatic t_sticky();
    do_reset(1'b1, 1'b0);
    wait_cyc(LIMIT + 1);
    chk("R5", "fault set", osc_fail, 1'b1);
    for (int i = 0; i < 20; i++) begin
      xtal_in = ~xtal_in;
      wait_cyc(5);
    end
    chk("R5", "fault holds with crystal back", osc_fail, 1'b1);
    chk("R7", "select holds PLL", clk_sel_pll, 1'b1);
    do_reset(1'b1, 1'b0);
    chk("R1", "reset clears fault", osc_fail, 1'b0);
    chk("R1", "reset restores crystal", clk_sel_pll, 1'b0);
  endtask

  initial begin
    t_reset_window();
    t_timeout_after_edge(1'b1);
    t_timeout_after_edge(1'b0);
    t_disabled_then_enabled();
    t_not_bypassed();
    t_sticky();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule